// File: doc/BRIEF.md
# Port input chattering filter

This block sits between eight raw input pins and the interrupt logic of a port. It brings every pin into the peripheral clock domain and filters out key-bounce glitches. Only after a level change has held long enough does it accept the new level and raise a per-pin interrupt flag. The pins form two groups of four: pins 3:0 and pins 7:4. Each group has its own 3-bit check-time code. Code 0 turns the filter off for that group. Codes 1 to 7 select a check time of 2^(7+code) peripheral clocks, which gives 256 up to 16384 cycles.

A level must stay steady for twice the check time before it is accepted. A pulse no wider than the check time therefore never reaches the flags. Each pin has a polarity bit that chooses whether a rising or a falling accepted edge sets its flag. A flag is cleared by writing 1 to its bit. A single interrupt output is the OR of every flag whose enable bit is set. Software reaches the registers through a simple bus with a write strobe and a combinational read port.

Top module: `port_debounce`

## Requirements
- R1: The control register (address 0) holds the code for pins 3:0 in bits 2:0 and the code for pins 7:4 in bits 6:4. Bits 7 and 3 always read 0. Both codes reset to 0.
- R2: With code 0 the filtered level of a pin follows the pin three clock edges after a change on the pin. Two of these edges are synchronizer stages and one is the accept register.
- R3: With code c from 1 to 7, a new level is accepted only after the synchronized pin has differed from the accepted level on 2^(8+c) consecutive edges. The filtered level changes 2^(8+c)+2 edges after a steady change on the pin.
- R4: A pulse shorter than 2^(8+c) cycles leaves the filtered level and the flag unchanged. This covers any pulse no wider than the check time 2^(7+c).
- R5: When a new level is accepted, the pin's flag sets if the new level equals its polarity bit (address 3; 1 means a rising edge, 0 means a falling edge). The flag sets on the same edge that the level is accepted.
- R6: Writing the flag register (address 2) clears each flag whose data bit is 1. Flags whose data bit is 0 keep their value.
- R7: irq_o is high exactly when some flag is set together with its enable bit (address 1). A flag that was set while its enable was off drives irq_o as soon as that enable is written to 1.
- R8: A write that changes a group's code restarts the counters of that group. A write that leaves a group's code unchanged does not disturb that group's counters.
- R9: Register addresses are 0 control, 1 enable, 2 flags and 3 polarity. rdata_o shows the addressed register combinationally. All registers reset to 0.
- R10: When a flag set and a write-1 clear of that flag fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 8 | Raw pin levels, asynchronous |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed register |
| level_o | output | 8 | Filtered, accepted pin levels |
| irq_o | output | 1 | Port interrupt request |

## Verification
The assertions take for granted that a group's code does not change in the same cycle that a new level is accepted. A rewrite of the code restarts the count, so the stimulus only changes a code while a count is running or the pins are idle. They also assume that pins change only away from the clock edge. The bench therefore drives pins and bus writes on the falling edge. It holds every long pulse for a whole number of cycles, so each accept edge can be predicted exactly.

// File: rtl/port_debounce_pkg.sv
package port_debounce_pkg;
  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_EN   = 2'd1,
    ADDR_FLAG = 2'd2,
    ADDR_POL  = 2'd3
  } pd_addr_e;
endpackage

// File: rtl/pd_sync.sv
module pd_sync #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/pd_filter.sv
module pd_filter #(
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic [SEL_W-1:0] code_i,
  input  logic             restart_i,
  input  logic             pol_i,
  output logic             level_o,
  output logic             evt_o
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q, lim;
  logic             acc_q, differ, at_lim, accept, bypass;

  // accept after 2^(BASE_LOG2+code) steady samples
  assign lim    = {CNT_W{1'b1}} >> (CNT_W - BASE_LOG2 - int'(code_i));
  assign bypass = (code_i == '0);
  assign differ = (lvl_i != acc_q);
  assign at_lim = (cnt_q == lim);
  assign accept = bypass ? differ : (differ && !restart_i && at_lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      acc_q <= 1'b0;
    end else begin
      if (bypass || restart_i || !differ || at_lim) cnt_q <= '0;
      else                                          cnt_q <= cnt_q + 1'b1;
      if (accept) acc_q <= lvl_i;
    end
  end

  assign level_o = acc_q;
  assign evt_o   = accept && (lvl_i == pol_i);
endmodule

// File: rtl/pd_regs.sv
module pd_regs
  import port_debounce_pkg::*;
#(
  parameter int NPINS    = 8,
  parameter int GRP_PINS = 4,
  parameter int SEL_W    = 3,
  localparam int NGRP    = NPINS / GRP_PINS,
  localparam int SLOT_W  = NPINS / NGRP
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [1:0]                 addr_i,
  input  logic [NPINS-1:0]           wdata_i,
  input  logic [NPINS-1:0]           evt_i,
  output logic [NPINS-1:0]           rdata_o,
  output logic [NGRP-1:0][SEL_W-1:0] code_o,
  output logic [NGRP-1:0]            restart_o,
  output logic [NPINS-1:0]           en_o,
  output logic [NPINS-1:0]           pol_o,
  output logic [NPINS-1:0]           flag_o
);
  logic [NGRP-1:0][SEL_W-1:0] code_q;
  logic [NPINS-1:0]           en_q, pol_q, flag_q, ctrl_rd, clr;
  logic                       wr_ctrl;

  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign clr     = (wr_i && addr_i == ADDR_FLAG) ? wdata_i : '0;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [SEL_W-1:0] wcode;
    assign wcode        = wdata_i[g*SLOT_W +: SEL_W];
    assign restart_o[g] = wr_ctrl && (wcode != code_q[g]);
    assign ctrl_rd[g*SLOT_W +: SLOT_W] = SLOT_W'(code_q[g]);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      code_q[g] <= '0;
      else if (wr_ctrl) code_q[g] <= wcode;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= '0;
      pol_q  <= '0;
      flag_q <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_EN)  en_q  <= wdata_i;
      if (wr_i && addr_i == ADDR_POL) pol_q <= wdata_i;
      flag_q <= (flag_q & ~clr) | evt_i;  // set wins
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_rd;
      ADDR_EN:   rdata_o = en_q;
      ADDR_FLAG: rdata_o = flag_q;
      default:   rdata_o = pol_q;
    endcase
  end

  assign code_o = code_q;
  assign en_o   = en_q;
  assign pol_o  = pol_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/port_debounce.sv
module port_debounce #(
  parameter int NPINS     = 8,
  parameter int GRP_PINS  = 4,
  parameter int SEL_W     = 3,
  parameter int BASE_LOG2 = 8,
  localparam int NGRP     = NPINS / GRP_PINS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pin_i,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] rdata_o,
  output logic [NPINS-1:0] level_o,
  output logic             irq_o
);
  logic [NPINS-1:0]           sync_s, evt_s, en_s, pol_s, flag_s;
  logic [NGRP-1:0][SEL_W-1:0] code_s;
  logic [NGRP-1:0]            restart_s;

  pd_sync #(.W(NPINS)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_i), .q_o(sync_s)
  );

  pd_regs #(.NPINS(NPINS), .GRP_PINS(GRP_PINS), .SEL_W(SEL_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .evt_i(evt_s), .rdata_o(rdata_o), .code_o(code_s),
    .restart_o(restart_s), .en_o(en_s), .pol_o(pol_s), .flag_o(flag_s)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    pd_filter #(.SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2)) u_filt (
      .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sync_s[i]),
      .code_i(code_s[i/GRP_PINS]), .restart_i(restart_s[i/GRP_PINS]),
      .pol_i(pol_s[i]), .level_o(level_o[i]), .evt_o(evt_s[i])
    );
  end

  assign irq_o = |(flag_s & en_s);
endmodule

// File: rtl/port_debounce_chk.sv
module port_debounce_chk #(
  parameter int NPINS    = 8,
  parameter int GRP_PINS = 4,
  parameter int SEL_W    = 3,
  localparam int NGRP    = NPINS / GRP_PINS
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       wr_i,
  input logic [1:0]                 addr_i,
  input logic [NPINS-1:0]           wdata_i,
  input logic [NPINS-1:0]           rdata_o,
  input logic [NPINS-1:0]           level_o,
  input logic                       irq_o,
  input logic [NPINS-1:0]           sync_s,
  input logic [NPINS-1:0]           flag_s,
  input logic [NPINS-1:0]           en_s,
  input logic [NPINS-1:0]           pol_s,
  input logic [NGRP-1:0][SEL_W-1:0] code_s
);
  assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i == 2'd0 |-> (rdata_o[7] == 1'b0 && rdata_o[3] == 1'b0));

  assert_no_irq_without_en_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_s == '0 |-> !irq_o);

  for (genvar i = 0; i < NPINS; i++) begin : g_p
    assert_accept_steady_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_s[i/GRP_PINS] != '0 && level_o[i] != $past(level_o[i]))
        |-> ($past(sync_s[i], 2) == level_o[i]));

    assert_flag_on_edge_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_s[i]) |-> (level_o[i] == pol_s[i] && level_o[i] != $past(level_o[i])));

    assert_flag_clear_by_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(flag_s[i]) |-> $past(wr_i && addr_i == 2'd2 && wdata_i[i]));
  end
endmodule

bind port_debounce port_debounce_chk #(
  .NPINS(NPINS), .GRP_PINS(GRP_PINS), .SEL_W(SEL_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .level_o(level_o), .irq_o(irq_o),
  .sync_s(sync_s), .flag_s(flag_s), .en_s(en_s), .pol_s(pol_s), .code_s(code_s)
);

// File: tb/port_debounce_tb.sv
module port_debounce_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] pins = '0;
  logic       wr = 1'b0;
  logic [1:0] addr = 2'd2;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, level;
  logic       irq;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  port_debounce dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .pin_i(pins), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .level_o(level), .irq_o(irq)
  );

  task automatic chk(input int act, input int exp, input string tag);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference
  logic [7:0] m_s1, m_s2, m_acc, m_ctrl, m_en, m_pol, m_flag;
  int         m_run [8];

  always @(posedge clk or negedge rst_ni) begin
    logic [7:0] setv;
    int code, nc;
    bit rs;
    if (!rst_ni) begin
      m_s1 = '0; m_s2 = '0; m_acc = '0; m_ctrl = '0;
      m_en = '0; m_pol = '0; m_flag = '0;
      for (int i = 0; i < 8; i++) m_run[i] = 0;
    end else begin
      setv = '0;
      for (int i = 0; i < 8; i++) begin
        code = (m_ctrl >> ((i / 4) * 4)) & 7;
        nc   = (wdata >> ((i / 4) * 4)) & 7;
        rs   = wr && addr == 2'd0 && nc != code;
        if (code == 0) begin
          m_run[i] = 0;
          if (m_s2[i] != m_acc[i]) begin
            m_acc[i] = m_s2[i];
            if (m_acc[i] == m_pol[i]) setv[i] = 1'b1;
          end
        end else if (rs || m_s2[i] == m_acc[i]) m_run[i] = 0;
        else if (m_run[i] == (1 << (8 + code)) - 1) begin
          m_run[i] = 0;
          m_acc[i] = m_s2[i];
          if (m_acc[i] == m_pol[i]) setv[i] = 1'b1;
        end else m_run[i]++;
      end
      m_s2 = m_s1;
      m_s1 = pins;
      m_flag = (m_flag & ~((wr && addr == 2'd2) ? wdata : 8'h00)) | setv;
      if (wr && addr == 2'd0) m_ctrl = wdata & 8'h77;
      if (wr && addr == 2'd1) m_en = wdata;
      if (wr && addr == 2'd3) m_pol = wdata;
    end
  end

  always @(posedge clk) begin
    #2;
    if (rst_ni) begin
      chk(int'(level), int'(m_acc), "R3 model level");
      chk(int'(irq), int'(|(m_flag & m_en)), "R7 model irq");
      if (addr == 2'd2 && !wr) chk(int'(rdata), int'(m_flag), "R5 model flags");
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0; addr = 2'd2; wdata = '0;
  endtask

  task automatic rreg(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk);
    addr = a;
    #1 chk(int'(rdata), exp, tag);
    addr = 2'd2;
  endtask

  initial begin
    #(200000 * 10);
    fails++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    // R9 reset values
    rreg(2'd0, 0, "R9 ctrl reset");
    rreg(2'd1, 0, "R9 en reset");
    rreg(2'd2, 0, "R9 flag reset");
    rreg(2'd3, 0, "R9 pol reset");
    chk(int'(irq), 0, "R7 irq reset");
    // R1 field layout / reserved bits
    wreg(2'd0, 8'hFF);
    rreg(2'd0, 8'h77, "R1 reserved bits");
    wreg(2'd0, 8'h00);
    rreg(2'd0, 8'h00, "R1 code clear");

    // R2 bypass latency
    @(negedge clk); pins[0] = 1'b1;
    idle(2); chk(int'(level[0]), 0, "R2 before third edge");
    idle(1); chk(int'(level[0]), 1, "R2 third edge");
    rreg(2'd2, 0, "R5 rising ignored with falling polarity");
    @(negedge clk); pins[0] = 1'b0;
    idle(5);
    rreg(2'd2, 8'h01, "R5 falling edge sets flag");
    chk(int'(irq), 0, "R7 masked flag");
    wreg(2'd1, 8'h01);
    chk(int'(irq), 1, "R7 stale flag asserts");
    // R6 write-1 clear
    wreg(2'd2, 8'h00);
    rreg(2'd2, 8'h01, "R6 write 0 keeps");
    wreg(2'd2, 8'h01);
    rreg(2'd2, 8'h00, "R6 write 1 clears");
    chk(int'(irq), 0, "R6 irq after clear");

    // R4/R3 low group code 1 (512), pin1 rising polarity
    wreg(2'd3, 8'h02);
    wreg(2'd0, 8'h01);
    @(negedge clk); pins[1] = 1'b1;
    idle(300);
    pins[1] = 1'b0;
    idle(600);
    chk(int'(level[1]), 0, "R4 short pulse rejected");
    rreg(2'd2, 0, "R4 no flag from pulse");
    pins[1] = 1'b1;
    idle(513); chk(int'(level[1]), 0, "R3 not yet at 513");
    idle(1);   chk(int'(level[1]), 1, "R3 accepted at 514");
    rreg(2'd2, 8'h02, "R5 rising sets flag");
    wreg(2'd2, 8'h02);

    // R8 restart on code change of the high group
    wreg(2'd3, 8'h10);
    wreg(2'd0, 8'h21);
    @(negedge clk); pins[4] = 1'b1;
    idle(300);
    pins[2] = 1'b1;
    idle(500);
    wreg(2'd0, 8'h11);
    idle(20);
    chk(int'(level[2]), 1, "R8 other group undisturbed");
    idle(280);
    chk(int'(level[4]), 0, "R8 restarted count");
    idle(300);
    chk(int'(level[4]), 1, "R8 accepted after restart");
    rreg(2'd2, 8'h10, "R8 flag pin4");
    wreg(2'd2, 8'hFF);

    // R10 set wins over same-cycle clear (low group bypass)
    wreg(2'd0, 8'h10);
    @(negedge clk); pins[3] = 1'b1;
    idle(6);
    pins[3] = 1'b0;
    idle(2);
    wr = 1'b1; addr = 2'd2; wdata = 8'h08;
    @(negedge clk);
    wr = 1'b0; wdata = '0;
    rreg(2'd2, 8'h08, "R10 set wins");
    wreg(2'd2, 8'h08);

    // R3 longest code on high group, pin5
    wreg(2'd0, 8'h70);
    @(negedge clk); pins[5] = 1'b1;
    idle(32769); chk(int'(level[5]), 0, "R3 code7 before");
    idle(1);     chk(int'(level[5]), 1, "R3 code7 accepted");

    idle(5);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule